// File: doc/BRIEF.md
# Table-Driven Disk Bit Sequencer

This block is the bit-level engine of a floppy disk controller. Each enabled clock it takes one step. It forms an 8-bit index from four inputs: the upper nibble of its current state, the write and sense mode bits, the most significant bit of its data shift register, and an active-low flux flag. It reads the next state from a 256-entry, byte-wide table held in on-chip memory. The low nibble of that entry picks what happens to the 8-bit data shift register.

The table has no fixed contents. It is written one byte per clock through a load port, so the same hardware can read nibbles, write nibbles or sense the write-protect line, depending on the program it is given. Flux transitions reported by the drive are stretched into a low pulse on the flux flag that lasts a fixed number of sequencer steps. In write mode, every step emits one bit for the drive: a 1 wherever state bit 7 toggles.

Every pin is a plain control or status signal. The write bit stream is marked with `write_valid` but has no ready input and no back-pressure. The receiver must accept one bit in each cycle that follows an enabled step in write mode. Stepping is paced entirely by `seq_en`.

Top module: `disk_seq_top`

## Requirements
- R1: After reset, `state_q` = 0x00, `data_q` = 0x00, `write_mode_q` = 0, `sense_mode_q` = 1, `flux_flag_n` = 1 and `write_valid` = 0.
- R2: On a clock edge with `seq_en` = 1, `state_q` takes table[idx], where idx = {state_q[7:4], write_mode_q, sense_mode_q, data_q[7], flux_flag_n} (bit 7 down to bit 0).
- R3: Action field = new state[3:0]. Code 0x8 leaves `data_q` unchanged. 0x9 shifts it left and inserts 0. 0xD shifts it left and inserts 1.
- R4: Action 0xA shifts `data_q` right and puts `wp_in` into bit 7.
- R5: Action 0xB loads `data_q` from `bus_data`.
- R6: Any other action code clears `data_q` to 0x00.
- R7: A `flux_evt` pulse drives `flux_flag_n` low on the next edge. It stays low for exactly PULSE_CYCLES (default 2) enabled steps and returns high on the edge that ends the last of them.
- R8: The index of each step uses `flux_flag_n` as it was before that step's countdown update.
- R9: An enabled step taken with `write_mode_q` = 1 sets `write_valid` = 1 for the following cycle. In that cycle `write_bit` = (new state bit 7) XOR (previous state bit 7). Otherwise `write_valid` is 0.
- R10: While `seq_en` = 0, `state_q`, `data_q` and the flux countdown hold their values.
- R11: A cycle with `tbl_we` = 1 writes `tbl_data` into entry `tbl_idx`. The next step that uses that index sees the new byte. Loading does not change `state_q` or `data_q`.
- R12: A cycle with `mode_we` = 1 loads `write_mode_q` from `mode_write_in` and `sense_mode_q` from `mode_sense_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_en | input | 1 | Take one sequencer step this cycle |
| mode_we | input | 1 | Load the mode register |
| mode_write_in | input | 1 | New write-mode value |
| mode_sense_in | input | 1 | New sense-mode value |
| wp_in | input | 1 | Write-protect level fed into the right shift |
| flux_evt | input | 1 | One-cycle pulse per flux transition |
| bus_data | input | 8 | Parallel load value |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 8 | Table write index |
| tbl_data | input | 8 | Table write byte |
| state_q | output | 8 | Current state |
| data_q | output | 8 | Data shift register |
| write_mode_q | output | 1 | Write mode bit |
| sense_mode_q | output | 1 | Sense mode bit |
| flux_flag_n | output | 1 | Stretched flux flag, active low |
| write_valid | output | 1 | `write_bit` holds a bit for the drive |
| write_bit | output | 1 | Write data bit (state bit 7 toggle) |

## Verification
The bench attacks the flux window by stepping through a table that counts in the state nibble how many steps saw the flag low. A design that updates the flag before forming the index counts one step instead of two. A stretcher that counts clocks rather than steps loses the pulse while `seq_en` is low. Separate table entries for data MSB = 0 and 1 expose an index built from the wrong bit: the state lands on the wrong nibble. In write mode, a sequence of states that toggles bit 7 and then holds it catches a design that outputs the level instead of the toggle. The clear-code sweep and a right shift with the protect line both high and low show up a wrong default action and a wrong fill bit.

// File: rtl/disk_seq_pkg.sv
package disk_seq_pkg;
  localparam int STATE_W = 8;

  localparam logic [3:0] ACT_NOP    = 4'h8;
  localparam logic [3:0] ACT_SHL0   = 4'h9;
  localparam logic [3:0] ACT_SHR_WP = 4'hA;
  localparam logic [3:0] ACT_LOAD   = 4'hB;
  localparam logic [3:0] ACT_SHL1   = 4'hD;

  typedef struct packed {
    logic [3:0] st_hi;
    logic       wr;
    logic       sense;
    logic       msb;
    logic       flux_n;
  } seq_idx_t;

  localparam int IDX_W = $bits(seq_idx_t);
endpackage

// File: rtl/disk_seq_flux.sv
module disk_seq_flux #(
  parameter int PULSE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic step,
  output logic flag_n
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_V = CW'(PULSE_CYCLES);
  localparam logic [CW-1:0] ONE_V  = CW'(1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      flag_n <= 1'b1;
    end else if (evt) begin
      remain <= LOAD_V;
      flag_n <= 1'b0;
    end else if (step && remain != '0) begin
      remain <= remain - ONE_V;
      if (remain == ONE_V) flag_n <= 1'b1;
    end
  end

  // R7
  evt_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !flag_n);

  // R10
  idle_holds_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !evt) |=> $stable(flag_n));
endmodule

// File: rtl/disk_seq_table.sv
module disk_seq_table #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/disk_seq_shreg.sv
module disk_seq_shreg
  import disk_seq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [3:0]   op,
  input  logic         wp,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb begin
    case (op)
      ACT_NOP:    nxt = q;
      ACT_SHL0:   nxt = {q[W-2:0], 1'b0};
      ACT_SHL1:   nxt = {q[W-2:0], 1'b1};
      ACT_SHR_WP: nxt = {wp, q[W-1:1]};
      ACT_LOAD:   nxt = load_val;
      default:    nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (step) q <= nxt;
  end

  // R5
  load_takes_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op == ACT_LOAD) |=> q == $past(load_val));

  // R4
  shr_fills_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op == ACT_SHR_WP) |=> q[W-1] == $past(wp));

  // R10
  idle_holds_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(q));
endmodule

// File: rtl/disk_seq_top.sv
module disk_seq_top
  import disk_seq_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int PULSE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_en,
  input  logic              mode_we,
  input  logic              mode_write_in,
  input  logic              mode_sense_in,
  input  logic              wp_in,
  input  logic              flux_evt,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [STATE_W-1:0] tbl_data,
  output logic [STATE_W-1:0] state_q,
  output logic [DATA_W-1:0] data_q,
  output logic              write_mode_q,
  output logic              sense_mode_q,
  output logic              flux_flag_n,
  output logic              write_valid,
  output logic              write_bit
);
  seq_idx_t           idx;
  logic [STATE_W-1:0] next_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_mode_q <= 1'b0;
      sense_mode_q <= 1'b1;
    end else if (mode_we) begin
      write_mode_q <= mode_write_in;
      sense_mode_q <= mode_sense_in;
    end
  end

  disk_seq_flux #(.PULSE_CYCLES(PULSE_CYCLES)) u_flux (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (flux_evt),
    .step   (seq_en),
    .flag_n (flux_flag_n)
  );

  always_comb begin
    idx.st_hi  = state_q[STATE_W-1 -: 4];
    idx.wr     = write_mode_q;
    idx.sense  = sense_mode_q;
    idx.msb    = data_q[DATA_W-1];
    idx.flux_n = flux_flag_n;
  end

  disk_seq_table #(.AW(IDX_W), .DW(STATE_W)) u_table (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_idx),
    .wdata (tbl_data),
    .raddr (idx),
    .rdata (next_state)
  );

  disk_seq_shreg #(.W(DATA_W)) u_shreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (seq_en),
    .op       (next_state[3:0]),
    .wp       (wp_in),
    .load_val (bus_data),
    .q        (data_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= '0;
      write_valid <= 1'b0;
      write_bit   <= 1'b0;
    end else begin
      write_valid <= seq_en && write_mode_q;
      if (seq_en) begin
        state_q <= next_state;
        if (write_mode_q) write_bit <= next_state[STATE_W-1] ^ state_q[STATE_W-1];
      end
    end
  end

  // R9
  read_step_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_en && !write_mode_q) |=> !write_valid);

  // R9
  write_bit_is_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_en && write_mode_q) |=> write_valid && (write_bit == (state_q[STATE_W-1] ^ $past(state_q[STATE_W-1]))));

  // R10
  idle_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_en |=> $stable(state_q));

  // R12
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (write_mode_q == $past(mode_write_in)) && (sense_mode_q == $past(mode_sense_in)));
endmodule

// File: tb/test_disk_seq_top.sv
module test_disk_seq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       seq_en = 1'b0;
  logic       mode_we = 1'b0, mode_write_in = 1'b0, mode_sense_in = 1'b0;
  logic       wp_in = 1'b0, flux_evt = 1'b0;
  logic [7:0] bus_data = 8'h00;
  logic       tbl_we = 1'b0;
  logic [7:0] tbl_idx = 8'h00, tbl_data = 8'h00;
  logic [7:0] state_q, data_q;
  logic       write_mode_q, sense_mode_q, flux_flag_n, write_valid, write_bit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  disk_seq_top i_disk_seq_top (
    .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .mode_we(mode_we),
    .mode_write_in(mode_write_in), .mode_sense_in(mode_sense_in),
    .wp_in(wp_in), .flux_evt(flux_evt), .bus_data(bus_data),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
    .state_q(state_q), .data_q(data_q), .write_mode_q(write_mode_q),
    .sense_mode_q(sense_mode_q), .flux_flag_n(flux_flag_n),
    .write_valid(write_valid), .write_bit(write_bit)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ix(input logic [3:0] hi, input logic w, input logic s,
                                    input logic m, input logic f);
    return {hi, w, s, m, f};
  endfunction

  task automatic load(input logic [7:0] i, input logic [7:0] v);
    @(negedge clk); tbl_we = 1'b1; tbl_idx = i; tbl_data = v;
    @(negedge clk); tbl_we = 1'b0;
  endtask

  task automatic step;
    @(negedge clk); seq_en = 1'b1;
    @(negedge clk); seq_en = 1'b0;
  endtask

  task automatic set_mode(input logic w, input logic s);
    @(negedge clk); mode_we = 1'b1; mode_write_in = w; mode_sense_in = s;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 state", state_q, 8'h00);
    check("R1 data", data_q, 8'h00);
    check("R1 modes/flag/valid", {4'h0, write_mode_q, sense_mode_q, flux_flag_n, write_valid},
          8'b0000_0110);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 256; i++) load(8'(i), 8'h08);
    check("R11 load leaves state", state_q, 8'h00);
    set_mode(1'b0, 1'b0);
    check("R12 mode load", {6'h0, write_mode_q, sense_mode_q}, 8'h00);
  endtask

  task automatic t_actions;
    bus_data = 8'h5A;
    load(8'h01, 8'h0B); step;
    check("R5 load bus", data_q, 8'h5A);
    check("R2 state from table", state_q, 8'h0B);
    load(8'h01, 8'h09); step;
    check("R3 shl0", data_q, 8'hB4);
    load(8'h03, 8'h0D); step;
    check("R3 shl1 (msb index)", data_q, 8'h69);
    wp_in = 1'b1; load(8'h01, 8'h0A); step;
    check("R4 shr wp=1", data_q, 8'hB4);
    wp_in = 1'b0; load(8'h03, 8'h0A); step;
    check("R4 shr wp=0", data_q, 8'h5A);
    load(8'h01, 8'h08); step;
    check("R3 nop", data_q, 8'h5A);
  endtask

  task automatic t_clear;
    logic [7:0] codes [4] = '{8'h00, 8'h05, 8'h0C, 8'h0F};
    foreach (codes[k]) begin
      load(8'h01, 8'h0B); step;
      load(8'h01, codes[k]); step;
      check("R6 clear code", data_q, 8'h00);
    end
    load(8'h01, 8'h08); step;
  endtask

  task automatic t_address;
    load(8'h01, 8'h38); step;
    check("R2 nibble jump", state_q, 8'h38);
    load(ix(4'h3, 0, 0, 0, 1), 8'h78); step;
    check("R2 state nibble index", state_q, 8'h78);
    set_mode(1'b0, 1'b1);
    load(ix(4'h7, 0, 1, 0, 1), 8'h08); step;
    check("R2 sense bit index", state_q, 8'h08);
    set_mode(1'b0, 1'b0);
    bus_data = 8'h80;
    load(8'h01, 8'h0B); step;
    load(8'h03, 8'h48); step;
    check("R2 data msb index", state_q, 8'h48);
    load(8'h41, 8'h08); step;
    check("R2 back to zero", state_q, 8'h08);
  endtask

  task automatic t_write;
    set_mode(1'b1, 1'b0);
    load(ix(4'h0, 1, 0, 1, 1), 8'h88);
    load(ix(4'h8, 1, 0, 1, 1), 8'h98);
    load(ix(4'h9, 1, 0, 1, 1), 8'h08);
    step;
    check("R9 toggle up", {6'h0, write_valid, write_bit}, 8'h03);
    step;
    check("R9 no toggle", {6'h0, write_valid, write_bit}, 8'h02);
    step;
    check("R9 toggle down", {6'h0, write_valid, write_bit}, 8'h03);
    check("R9 state", state_q, 8'h08);
    set_mode(1'b0, 1'b0);
    load(8'h03, 8'h08); step;
    check("R9 read mode silent", {7'h0, write_valid}, 8'h00);
  endtask

  task automatic t_flux;
    load(8'h03, 8'h00); step;
    check("R6 clear before flux", data_q, 8'h00);
    for (int n = 0; n < 4; n++) begin
      load(ix(4'(n), 0, 0, 0, 1), {4'(n), 4'h8});
      load(ix(4'(n), 0, 0, 0, 0), {4'(n + 1), 4'h8});
    end
    @(negedge clk); flux_evt = 1'b1;
    @(negedge clk); flux_evt = 1'b0;
    check("R7 flag drops", {7'h0, flux_flag_n}, 8'h00);
    repeat (3) @(negedge clk);
    check("R10 flag held while idle", {7'h0, flux_flag_n}, 8'h00);
    check("R10 state held while idle", state_q, 8'h00);
    step;
    check("R8 first low step", state_q, 8'h18);
    check("R7 still low", {7'h0, flux_flag_n}, 8'h00);
    step;
    check("R8 second step uses old flag", state_q, 8'h28);
    check("R7 flag released", {7'h0, flux_flag_n}, 8'h01);
    step;
    check("R7 third step sees high", state_q, 8'h28);
  endtask

  task automatic t_reload;
    load(ix(4'h2, 0, 0, 0, 1), 8'hC8);
    check("R11 load holds state", state_q, 8'h28);
    step;
    check("R11 new byte used", state_q, 8'hC8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_fill;
    t_actions;
    t_clear;
    t_address;
    t_write;
    t_flux;
    t_reload;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule